// File: doc/BRIEF.md
# Two-Phase Module Conformance Monitor

This block is a clocked watchdog for one self-timed, two-phase component. Every clock edge it compares the present levels of the component's wires against the levels it saw at the previous edge. Each level change, whether rising or falling, counts as one event. The monitor then decides whether that set of events is an ordering the component's behavioural rule permits. The rule assumes the environment works in fundamental mode: it may drive an input only while the component is stable, and a pending component must answer with an output change before anything else happens.

A parameter picks the component being watched. The choices are a two-input merge (exclusive-or), an inverter, a rendezvous (C) element, a rendezvous element whose first input is inverted, or a toggle with one input and two alternating outputs. On any violation the monitor raises a one-cycle error pulse together with a cause code. It also sets a sticky flag and keeps the first cause until reset. The wires must reach the monitor already synchronised to its clock.

Top module: `di_conformance_monitor`

## Requirements
- R1: While `rst` is sampled high, the monitor loads its remembered wire levels from `INIT` (bit 3 = in_a, 2 = in_b, 1 = out_y, 0 = out_z). On the edge that samples `rst` high it clears `err_pulse`, `err_code`, `err_sticky` and `err_first` to 0.
- R2: Merge mode (`MODE`=0). The component is stable when in_a XOR in_b equals out_z. A single input change is legal only from a stable state, and an out_z change is legal only from an unstable one.
- R3: An input change arriving while the component is not ready for it gives code 1. This covers an unstable component and, for the rendezvous modes, an input that has already changed since the last output.
- R4: In modes that watch two inputs (0, 2, 3), changes on in_a and in_b seen at the same edge give code 2. This code has priority over every other code.
- R5: An output change the rule does not enable gives code 3. In the rendezvous modes this includes an out_z change before both inputs have changed.
- R6: Inverter mode (`MODE`=1). The component is stable when out_z is the complement of in_a. From the unstable start state (in_a = out_z), the events must alternate out_z, in_a, out_z, and so on.
- R7: Rendezvous mode (`MODE`=2). out_z may change only after in_a and in_b have each changed once since the last out_z change, in either order. Mode 3 applies the same rule to the inverse of in_a, so from an all-low start in_b and then out_z are expected first.
- R8: Toggle mode (`MODE`=4). Events must repeat in_a, out_y, in_a, out_z. Any other event, including out_y and out_z together, gives code 4.
- R9: When one edge shows both a legal input change and the output change that this input enables, the input is applied first and the pair is accepted without error.
- R10: Changes on a wire the selected mode does not use are ignored. The unused wires are in_b and out_y for the inverter, out_y for merge and both rendezvous modes, and in_b for toggle.
- R11: `err_pulse` and `err_code` are registered on the same edge that samples the offending levels. They hold for exactly one cycle, and the next edge with no violation returns them to 0.
- R12: `err_sticky` is set by the first violation and stays set until reset. `err_first` captures that violation's code and ignores all later ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | First input wire of the watched component |
| in_b | input | 1 | Second input wire (merge and rendezvous modes) |
| out_y | input | 1 | First output wire (toggle mode) |
| out_z | input | 1 | Main output wire (second output in toggle mode) |
| err_pulse | output | 1 | One-cycle violation strobe |
| err_code | output | 3 | Cause of this cycle's violation, 0 when none |
| err_sticky | output | 1 | Set by any violation since reset |
| err_first | output | 3 | Cause code of the first violation since reset |

## Verification
Wire changes are driven at the falling edge. The next rising edge both detects them and registers the verdict, so `err_pulse` and `err_code` are compared at the falling edge one half period later. `err_sticky` and `err_first` are compared at the same point, and again one full cycle afterwards when the pulse must already have dropped. Reset values are read at the falling edge after the edge that samples `rst` high. The bench keeps its own event-counting model of each component, advanced only when a sample is legal, so each comparison uses the verdict that belongs to that single edge.

// File: rtl/di_mon_pkg.sv
package di_mon_pkg;

   localparam int NUM_WIRES   = 4;
   localparam int WA          = 3;
   localparam int WB          = 2;
   localparam int WY          = 1;
   localparam int WZ          = 0;
   localparam int CODE_W      = 3;

   localparam int MODE_MERGE  = 0;
   localparam int MODE_INV    = 1;
   localparam int MODE_CEL    = 2;
   localparam int MODE_ICEL   = 3;
   localparam int MODE_TOGGLE = 4;
   localparam int MODE_LAST   = MODE_TOGGLE;

   typedef enum logic [CODE_W-1:0] {
      ERR_NONE       = 3'd0,
      ERR_IN_BLOCKED = 3'd1,
      ERR_IN_PAIR    = 3'd2,
      ERR_OUT_EARLY  = 3'd3,
      ERR_TOG_SEQ    = 3'd4
   } err_code_e;

   localparam logic [NUM_WIRES-1:0] IN_MASK = 4'b1100;

   function automatic logic [NUM_WIRES-1:0] used_mask(input int mode);
      case (mode)
         MODE_INV:    return 4'b1001;
         MODE_TOGGLE: return 4'b1011;
         default:     return 4'b1101;
      endcase
   endfunction

endpackage

// File: rtl/di_edge_track.sv
module di_edge_track #(
   parameter int           W    = 4,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lv_i,
   output logic [W-1:0] prev_o,
   output logic [W-1:0] ev_o
);

   for (genvar i = 0; i < W; i++) begin : g_wire
      always_ff @(posedge clk) begin
         if (rst) prev_o[i] <= INIT[i];
         else     prev_o[i] <= lv_i[i];
      end
      assign ev_o[i] = lv_i[i] ^ prev_o[i];
   end

endmodule

// File: rtl/di_rule_eval.sv
module di_rule_eval
   import di_mon_pkg::*;
#(
   parameter int MODE = MODE_MERGE
) (
   input  logic [NUM_WIRES-1:0] prev_i,
   input  logic [NUM_WIRES-1:0] ev_i,
   output err_code_e            code_o
);

   logic [NUM_WIRES-1:0] mid;
   assign mid = prev_i ^ (ev_i & IN_MASK);

   if (MODE == MODE_MERGE) begin : g_merge
      logic st_prev, st_mid, unused_bits;
      assign st_prev     = (prev_i[WA] ^ prev_i[WB]) == prev_i[WZ];
      assign st_mid      = (mid[WA] ^ mid[WB]) == mid[WZ];
      assign unused_bits = ^{prev_i[WY], ev_i[WY], mid[WY]};
      always_comb begin
         code_o = ERR_NONE;
         if (ev_i[WA] && ev_i[WB])                    code_o = ERR_IN_PAIR;
         else if ((ev_i[WA] || ev_i[WB]) && !st_prev) code_o = ERR_IN_BLOCKED;
         else if (ev_i[WZ] && st_mid)                 code_o = ERR_OUT_EARLY;
      end
   end else if (MODE == MODE_INV) begin : g_inv
      logic st_prev, st_mid, unused_bits;
      assign st_prev     = prev_i[WZ] != prev_i[WA];
      assign st_mid      = mid[WZ] != mid[WA];
      assign unused_bits = ^{prev_i[WB], prev_i[WY], ev_i[WB], ev_i[WY],
                             mid[WB], mid[WY]};
      always_comb begin
         code_o = ERR_NONE;
         if (ev_i[WA] && !st_prev)    code_o = ERR_IN_BLOCKED;
         else if (ev_i[WZ] && st_mid) code_o = ERR_OUT_EARLY;
      end
   end else if (MODE == MODE_CEL || MODE == MODE_ICEL) begin : g_cel
      localparam logic INV_A = (MODE == MODE_ICEL);
      logic pa_prev, pb_prev, pa_mid, pb_mid, unused_bits;
      assign pa_prev     = (prev_i[WA] ^ INV_A) != prev_i[WZ];
      assign pb_prev     = prev_i[WB] != prev_i[WZ];
      assign pa_mid      = (mid[WA] ^ INV_A) != mid[WZ];
      assign pb_mid      = mid[WB] != mid[WZ];
      assign unused_bits = ^{prev_i[WY], ev_i[WY], mid[WY]};
      always_comb begin
         code_o = ERR_NONE;
         if (ev_i[WA] && ev_i[WB])
            code_o = ERR_IN_PAIR;
         else if ((ev_i[WA] && pa_prev) || (ev_i[WB] && pb_prev))
            code_o = ERR_IN_BLOCKED;
         else if (ev_i[WZ] && !(pa_mid && pb_mid))
            code_o = ERR_OUT_EARLY;
      end
   end else begin : g_toggle
      logic pend_prev, pend_mid, want_z, unused_bits;
      assign pend_prev   = prev_i[WA] ^ prev_i[WY] ^ prev_i[WZ];
      assign pend_mid    = mid[WA] ^ mid[WY] ^ mid[WZ];
      assign want_z      = mid[WY] ^ mid[WZ];
      assign unused_bits = ^{prev_i[WB], ev_i[WB], mid[WB]};
      always_comb begin
         code_o = ERR_NONE;
         if (ev_i[WA] && pend_prev)                     code_o = ERR_TOG_SEQ;
         else if (ev_i[WY] && ev_i[WZ])                 code_o = ERR_TOG_SEQ;
         else if (ev_i[WY] && !(pend_mid && !want_z))   code_o = ERR_TOG_SEQ;
         else if (ev_i[WZ] && !(pend_mid && want_z))    code_o = ERR_TOG_SEQ;
      end
   end

endmodule

// File: rtl/di_err_hold.sv
module di_err_hold
   import di_mon_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  err_code_e         code_i,
   output logic              err_pulse,
   output logic [CODE_W-1:0] err_code,
   output logic              err_sticky,
   output logic [CODE_W-1:0] err_first
);

   always_ff @(posedge clk) begin
      if (rst) begin
         err_pulse  <= 1'b0;
         err_code   <= '0;
         err_sticky <= 1'b0;
         err_first  <= '0;
      end else begin
         err_pulse <= (code_i != ERR_NONE);
         err_code  <= code_i;
         if (code_i != ERR_NONE && !err_sticky) begin
            err_sticky <= 1'b1;
            err_first  <= code_i;
         end
      end
   end

   // R12
   pulse_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      err_pulse |-> err_sticky);

   // R12
   sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      err_sticky |=> err_sticky);

   // R12
   first_hold_chk: assert property (@(posedge clk) disable iff (rst)
      err_sticky |=> $stable(err_first));

endmodule

// File: rtl/di_conformance_monitor.sv
module di_conformance_monitor
   import di_mon_pkg::*;
#(
   parameter int                   MODE = MODE_MERGE,
   parameter logic [NUM_WIRES-1:0] INIT = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_a,
   input  logic              in_b,
   input  logic              out_y,
   input  logic              out_z,
   output logic              err_pulse,
   output logic [CODE_W-1:0] err_code,
   output logic              err_sticky,
   output logic [CODE_W-1:0] err_first
);

   localparam logic [NUM_WIRES-1:0] USED = used_mask(MODE);

   if (MODE < 0 || MODE > MODE_LAST) begin : g_mode_bad
      $error("di_conformance_monitor: MODE outside 0..4");
   end

   logic [NUM_WIRES-1:0] lv, prev, ev_raw, ev_m;
   err_code_e            code;

   assign lv   = {in_a, in_b, out_y, out_z};
   assign ev_m = ev_raw & USED;

   di_edge_track #(.W(NUM_WIRES), .INIT(INIT)) u_track (
      .clk    (clk),
      .rst    (rst),
      .lv_i   (lv),
      .prev_o (prev),
      .ev_o   (ev_raw)
   );

   di_rule_eval #(.MODE(MODE)) u_rule (
      .prev_i (prev),
      .ev_i   (ev_m),
      .code_o (code)
   );

   di_err_hold u_hold (
      .clk        (clk),
      .rst        (rst),
      .code_i     (code),
      .err_pulse  (err_pulse),
      .err_code   (err_code),
      .err_sticky (err_sticky),
      .err_first  (err_first)
   );

   // R4
   pair_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (ev_m[WA] && ev_m[WB]) |=> (err_pulse && err_code == ERR_IN_PAIR));

   // R11
   quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (ev_m == '0) |=> !err_pulse);

endmodule

// File: tb/di_conformance_monitor_tb.sv
module di_conformance_monitor_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NMODES     = 5;
   localparam int STEPS      = 300;
   localparam int WATCHDOG   = 150000;

   logic clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic [NMODES-1:0]      rst_v = '1;
   logic [NMODES-1:0][3:0] lv    = '0;
   logic [NMODES-1:0]      pulse, sticky;
   logic [NMODES-1:0][2:0] code_o, first_o;

   for (genvar m = 0; m < NMODES; m++) begin : g_mode
      di_conformance_monitor #(.MODE(m), .INIT(4'b0000)) u_dut (
         .clk        (clk),
         .rst        (rst_v[m]),
         .in_a       (lv[m][3]),
         .in_b       (lv[m][2]),
         .out_y      (lv[m][1]),
         .out_z      (lv[m][0]),
         .err_pulse  (pulse[m]),
         .err_code   (code_o[m]),
         .err_sticky (sticky[m]),
         .err_first  (first_o[m])
      );
   end

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   int ph;
   bit ca, cb;
   logic [15:0] lfsr = 16'hACE1;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [3:0] used_of(input int m);
      if (m == 1) return 4'b1001;
      if (m == 4) return 4'b1011;
      return 4'b1101;
   endfunction

   task automatic next_rand(output int v);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = int'(lfsr);
   endtask

   task automatic model_reset(input int m);
      ph = 0;
      ca = (m == 3);
      cb = 1'b0;
   endtask

   // Event-counting model of each component; bits: 3=a 2=b 1=y 0=z
   task automatic model_apply(input int m, input logic [3:0] ev, output int code);
      logic [3:0] e;
      e = ev & used_of(m);
      code = 0;
      case (m)
         0: begin
            if (e[3] && e[2]) code = 2;
            else begin
               if (e[3] || e[2]) begin
                  if (ph != 0) code = 1; else ph = 1;
               end
               if (code == 0 && e[0]) begin
                  if (ph != 1) code = 3; else ph = 0;
               end
            end
         end
         1: begin
            if (e[3]) begin
               if (ph != 1) code = 1; else ph = 0;
            end
            if (code == 0 && e[0]) begin
               if (ph != 0) code = 3; else ph = 1;
            end
         end
         2, 3: begin
            if (e[3] && e[2]) code = 2;
            else begin
               if (e[3]) begin
                  if (ca) code = 1; else ca = 1'b1;
               end
               if (e[2]) begin
                  if (cb) code = 1; else cb = 1'b1;
               end
               if (code == 0 && e[0]) begin
                  if (!(ca && cb)) code = 3;
                  else begin ca = 1'b0; cb = 1'b0; end
               end
            end
         end
         default: begin
            if (e[3]) begin
               if (ph == 0) ph = 1;
               else if (ph == 2) ph = 3;
               else code = 4;
            end
            if (code == 0) begin
               if (e[1] && e[0]) code = 4;
               else if (e[1]) begin
                  if (ph == 1) ph = 2; else code = 4;
               end else if (e[0]) begin
                  if (ph == 3) ph = 0; else code = 4;
               end
            end
         end
      endcase
   endtask

   function automatic logic [3:0] legal_pick(input int m, input bit rb, input bit fast);
      case (m)
         0: return (ph == 0) ? ((rb ? 4'b1000 : 4'b0100) | (fast ? 4'b0001 : 4'b0000))
                             : 4'b0001;
         1: return (ph == 0) ? 4'b0001 : (4'b1000 | (fast ? 4'b0001 : 4'b0000));
         2, 3: begin
            if (!ca && !cb) return rb ? 4'b1000 : 4'b0100;
            if (!ca)        return 4'b1000 | (fast ? 4'b0001 : 4'b0000);
            if (!cb)        return 4'b0100 | (fast ? 4'b0001 : 4'b0000);
            return 4'b0001;
         end
         default: begin
            if (ph == 0) return 4'b1000 | (fast ? 4'b0010 : 4'b0000);
            if (ph == 1) return 4'b0010;
            if (ph == 2) return 4'b1000 | (fast ? 4'b0001 : 4'b0000);
            return 4'b0001;
         end
      endcase
   endfunction

   function automatic string tag_for(input int m, input int code, input logic [3:0] ev);
      logic [3:0] e;
      e = ev & used_of(m);
      if (ev != 0 && e == 0) return "R10";
      case (code)
         1: return "R3";
         2: return "R4";
         3: return "R5";
         4: return "R8";
         default: ;
      endcase
      if ((e[3] || e[2]) && (e[1] || e[0])) return "R9";
      if (m == 0) return "R2";
      if (m == 1) return "R6";
      if (m == 4) return "R8";
      return "R7";
   endfunction

   // Called at a falling edge; returns at a falling edge with rst released
   task automatic do_reset(input int m);
      lv[m]    = 4'b0000;
      rst_v[m] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check(pulse[m] == 1'b0, "R1", "reset err_pulse", int'(pulse[m]), 0);
      check(code_o[m] == 3'd0, "R1", "reset err_code", int'(code_o[m]), 0);
      check(sticky[m] == 1'b0, "R1", "reset err_sticky", int'(sticky[m]), 0);
      check(first_o[m] == 3'd0, "R1", "reset err_first", int'(first_o[m]), 0);
      rst_v[m] = 1'b0;
      model_reset(m);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      for (int m = 0; m < NMODES; m++) begin
         do_reset(m);
         for (int s = 0; s < STEPS; s++) begin
            int r, code;
            logic [3:0] ev;
            string tag;
            next_rand(r);
            if (r % 16 < 9)       ev = legal_pick(m, r[5], (r % 16) < 3);
            else if (r % 16 < 13) ev = 4'b0001 << ((r >> 6) % 4);
            else if (r % 16 < 15) ev = 4'(r >> 8);
            else                  ev = 4'b0000;
            tag = tag_for(m, 0, ev);
            model_apply(m, ev, code);
            if (code != 0) tag = tag_for(m, code, ev);
            lv[m] = lv[m] ^ ev;
            @(posedge clk);
            @(negedge clk);
            check(pulse[m] == (code != 0), tag, "err_pulse", int'(pulse[m]), int'(code != 0));
            check(int'(code_o[m]) == code, tag, "err_code", int'(code_o[m]), code);
            if (code == 0) begin
               check(sticky[m] == 1'b0, tag, "err_sticky idle", int'(sticky[m]), 0);
            end else begin
               check(sticky[m] == 1'b1, "R12", "err_sticky set", int'(sticky[m]), 1);
               check(int'(first_o[m]) == code, "R12", "err_first", int'(first_o[m]), code);
               @(posedge clk);
               @(negedge clk);
               check(pulse[m] == 1'b0, "R11", "err_pulse drop", int'(pulse[m]), 0);
               check(code_o[m] == 3'd0, "R11", "err_code drop", int'(code_o[m]), 0);
               check(sticky[m] == 1'b1, "R12", "err_sticky hold", int'(sticky[m]), 1);
               check(int'(first_o[m]) == code, "R12", "err_first hold", int'(first_o[m]), code);
               do_reset(m);
            end
         end
         rst_v[m] = 1'b1;
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule